// File: doc/BRIEF.md
# PASID Command Mailbox

This block is a small memory-mapped mailbox. Software uses it to obtain and return process address-space identifiers (PASIDs). It sits on a plain register port that carries 32-bit or 64-bit accesses. It holds three 64-bit registers:

- a read-only capability word at 0xE00;
- a command word at 0xE10, which software writes;
- a read-only response word at 0xE20.

The upper half of each register is reached at the base offset plus 4.

A write to the command word decodes its low byte as an opcode.

- **Allocate (1)** hands out the lowest free identifier from a bitmap pool. The pool covers `POOL` consecutive values starting at `MIN_ID` (200).
- **Free (2)** returns the identifier found in command bits 27:8.

While either operation runs, bit 0 of the response word reads 1. When it finishes, the block posts one of two outcomes to the response word and clears bit 0:

- a result, carried in bits 27:8;
- a two-bit status code, carried in bits 2:1.

The pool scan examines `CHUNK` bitmap entries per cycle, so an allocate takes between 1 and `POOL/CHUNK` cycles.

Software polls bit 0 of the response word and then reads the outcome. A command written while bit 0 is set is dropped. An allocate or free is also dropped when the capability is absent.

Top module: `vcmd_unit`

## Requirements
- R1: After reset the capability word at 0xE00 reads 1 in bit 0 when `CAP_EN` is 1 and 0 when it is 0, and reads 0 in every other bit. The response word at 0xE20 reads 0. A read at a base offset plus 4 returns that register's bits 63:32 in bits 31:0.
- R2: Writing opcode 1 (allocate) or 2 (free) in command bits 7:0 sets response bit 0 from the cycle after the write. Bit 0 returns to 0 when the outcome is posted.
- R3: A successful allocate posts the lowest unallocated identifier in the range MIN_ID to MIN_ID+POOL-1. The identifier goes in response bits 27:8, with status bits 2:1 equal to 0.
- R4: An allocate when every identifier in the pool is taken posts status 2 in bits 2:1 and a zero result field.
- R5: A free whose command bits 27:8 name an allocated identifier posts status 0. The identifier becomes the lowest candidate again for later allocates.
- R6: A free naming an identifier outside the pool range, or one not currently allocated, posts status 2 and changes no allocation.
- R7: Any opcode other than 1 or 2 posts status 1, with a zero result, in the cycle after the write. Response bit 0 is never set for such an opcode.
- R8: Each accepted command clears the previous status and result fields before it runs.
- R9: A command write that arrives while response bit 0 is set is dropped, including one in the cycle the outcome is being posted. It does not restart the allocator.
- R10: With the capability clear, allocate and free writes leave the response word unchanged.
- R11: A 32-bit write at 0xE10 replaces command bits 31:0 and a write at 0xE14 replaces bits 63:32. Each such write runs the merged command. Writes to the capability and response words have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write byte offset |
| wr_wide | input | 1 | 1 for a 64-bit write, 0 for 32-bit |
| wr_data | input | 64 | Write data (bits 31:0 for 32-bit writes) |
| rd_addr | input | ADDR_W | Read byte offset |
| rd_data | output | 64 | Read data for rd_addr, combinational |

## Verification
Two events can fall in the same cycle: the allocator posting its outcome, and a new command write arriving. The bench provokes this by issuing two allocate writes on consecutive cycles while exactly one identifier is free in the first scan group. The second write is then sampled in the very cycle the first allocate completes. The bench judges the outcome in two steps. First, the posted result must be the first identifier. Second, a following single allocate must return the next free identifier, which proves that the colliding write neither restarted the allocator nor consumed a slot.

// File: rtl/vcmd_pkg.sv
package vcmd_pkg;

    localparam int PASID_W = 20;

    localparam logic [11:0] OFS_CAP = 12'hE00;
    localparam logic [11:0] OFS_CMD = 12'hE10;
    localparam logic [11:0] OFS_RSP = 12'hE20;

    localparam logic [7:0] OP_ALLOC = 8'd1;
    localparam logic [7:0] OP_FREE  = 8'd2;

    localparam logic [1:0] ST_OK    = 2'd0;
    localparam logic [1:0] ST_UNDEF = 2'd1;
    localparam logic [1:0] ST_FAIL  = 2'd2;

    typedef struct packed {
        logic [35:0]        rsvd_hi;
        logic [PASID_W-1:0] result;
        logic [4:0]         rsvd_lo;
        logic [1:0]         status;
        logic               busy;
    } rsp_t;

endpackage

// File: rtl/vcmd_wrdec.sv
module vcmd_wrdec #(
    parameter int ADDR_W = 12
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_wide,
    input  logic [63:0]       wr_data,
    input  logic [63:0]       cmd_cur,
    output logic              cmd_wr,
    output logic [63:0]       cmd_new
);
    import vcmd_pkg::*;

    localparam logic [ADDR_W-1:0] CMD_LO = ADDR_W'(OFS_CMD);
    localparam logic [ADDR_W-1:0] CMD_HI = ADDR_W'(OFS_CMD + 12'd4);

    always_comb begin
        cmd_wr  = 1'b0;
        cmd_new = cmd_cur;
        if (wr_en && wr_addr == CMD_LO) begin
            cmd_wr  = 1'b1;
            cmd_new = wr_wide ? wr_data : {cmd_cur[63:32], wr_data[31:0]};
        end else if (wr_en && wr_addr == CMD_HI) begin
            cmd_wr  = 1'b1;
            cmd_new = {wr_data[31:0], cmd_cur[31:0]};
        end
    end
endmodule

// File: rtl/vcmd_rdmux.sv
module vcmd_rdmux #(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [63:0]       cap_w,
    input  logic [63:0]       cmd_w,
    input  logic [63:0]       rsp_w,
    output logic [63:0]       rd_data
);
    import vcmd_pkg::*;

    always_comb begin
        rd_data = '0;
        if      (rd_addr == ADDR_W'(OFS_CAP))         rd_data = cap_w;
        else if (rd_addr == ADDR_W'(OFS_CAP + 12'd4)) rd_data = {32'b0, cap_w[63:32]};
        else if (rd_addr == ADDR_W'(OFS_CMD))         rd_data = cmd_w;
        else if (rd_addr == ADDR_W'(OFS_CMD + 12'd4)) rd_data = {32'b0, cmd_w[63:32]};
        else if (rd_addr == ADDR_W'(OFS_RSP))         rd_data = rsp_w;
        else if (rd_addr == ADDR_W'(OFS_RSP + 12'd4)) rd_data = {32'b0, rsp_w[63:32]};
    end
endmodule

// File: rtl/vcmd_pool.sv
module vcmd_pool #(
    parameter int MIN_ID = 200,
    parameter int POOL   = 16,
    parameter int CHUNK  = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start_alloc,
    input  logic                        start_free,
    input  logic [vcmd_pkg::PASID_W-1:0] free_id,
    output logic                        done,
    output logic                        ok,
    output logic [vcmd_pkg::PASID_W-1:0] out_id
);
    import vcmd_pkg::*;

    localparam int NCHUNK = POOL / CHUNK;
    localparam int CW     = (NCHUNK > 1) ? $clog2(NCHUNK) : 1;
    localparam int IW     = (POOL > 1) ? $clog2(POOL) : 1;

    typedef enum logic [1:0] {M_IDLE, M_SCAN, M_REL} mode_e;

    typedef struct packed {
        mode_e           mode;
        logic [POOL-1:0] map;
        logic [CW-1:0]   chunk;
        logic [IW-1:0]   rel_idx;
        logic            rel_ok;
    } pool_st_t;

    pool_st_t st_d, st_q;
    logic [CHUNK-1:0] win;
    logic             hit;
    int               sel;
    logic [IW-1:0]    slot;

    always_comb begin
        st_d   = st_q;
        done   = 1'b0;
        ok     = 1'b0;
        out_id = '0;
        win    = st_q.map[int'(st_q.chunk)*CHUNK +: CHUNK];
        hit    = 1'b0;
        sel    = 0;
        for (int i = CHUNK - 1; i >= 0; i--) begin
            if (!win[i]) begin
                hit = 1'b1;
                sel = i;
            end
        end
        slot = IW'(int'(st_q.chunk) * CHUNK + sel);

        case (st_q.mode)
            M_IDLE: begin
                if (start_alloc) begin
                    st_d.mode  = M_SCAN;
                    st_d.chunk = '0;
                end else if (start_free) begin
                    st_d.mode    = M_REL;
                    st_d.rel_idx = IW'(int'(free_id) - MIN_ID);
                    st_d.rel_ok  = (int'(free_id) >= MIN_ID) &&
                                   (int'(free_id) < MIN_ID + POOL);
                end
            end
            M_SCAN: begin
                if (hit) begin
                    done            = 1'b1;
                    ok              = 1'b1;
                    out_id          = PASID_W'(MIN_ID + int'(slot));
                    st_d.map[slot]  = 1'b1;
                    st_d.mode       = M_IDLE;
                end else if (st_q.chunk == CW'(NCHUNK - 1)) begin
                    done      = 1'b1;
                    st_d.mode = M_IDLE;
                end else begin
                    st_d.chunk = st_q.chunk + CW'(1);
                end
            end
            M_REL: begin
                done      = 1'b1;
                st_d.mode = M_IDLE;
                if (st_q.rel_ok && st_q.map[st_q.rel_idx]) begin
                    ok                        = 1'b1;
                    st_d.map[st_q.rel_idx]    = 1'b0;
                end
            end
            default: st_d.mode = M_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{mode: M_IDLE, default: '0};
        else        st_q <= st_d;
    end

    a_r3_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ok && st_q.mode == M_SCAN) |->
            (int'(out_id) >= MIN_ID && int'(out_id) < MIN_ID + POOL));

    a_r3_slot_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ok && st_q.mode == M_SCAN) |=> st_q.map[$past(slot)]);

    a_r5_slot_released: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ok && st_q.mode == M_REL) |=> !st_q.map[$past(st_q.rel_idx)]);

    a_r6_map_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !ok && st_q.mode == M_REL) |=> $stable(st_q.map));

    a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode != M_IDLE) |-> !(start_alloc || start_free));
endmodule

// File: rtl/vcmd_unit.sv
module vcmd_unit #(
    parameter int ADDR_W = 12,
    parameter int CAP_EN = 1,
    parameter int MIN_ID = 200,
    parameter int POOL   = 16,
    parameter int CHUNK  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_wide,
    input  logic [63:0]       wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [63:0]       rd_data
);
    import vcmd_pkg::*;

    localparam logic [63:0] CAP_WORD = {63'b0, CAP_EN != 0};

    typedef struct packed {
        logic [63:0] cmd;
        rsp_t        rsp;
    } unit_st_t;

    unit_st_t st_d, st_q;

    logic               cmd_wr;
    logic [63:0]        cmd_new;
    logic               go_alloc, go_free;
    logic               pool_done, pool_ok;
    logic [PASID_W-1:0] pool_id;
    logic [7:0]         opcode;

    vcmd_wrdec #(.ADDR_W(ADDR_W)) u_wrdec (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_wide (wr_wide),
        .wr_data (wr_data),
        .cmd_cur (st_q.cmd),
        .cmd_wr  (cmd_wr),
        .cmd_new (cmd_new)
    );

    vcmd_pool #(.MIN_ID(MIN_ID), .POOL(POOL), .CHUNK(CHUNK)) u_pool (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_alloc (go_alloc),
        .start_free  (go_free),
        .free_id     (cmd_new[8 +: PASID_W]),
        .done        (pool_done),
        .ok          (pool_ok),
        .out_id      (pool_id)
    );

    vcmd_rdmux #(.ADDR_W(ADDR_W)) u_rdmux (
        .rd_addr (rd_addr),
        .cap_w   (CAP_WORD),
        .cmd_w   (st_q.cmd),
        .rsp_w   (st_q.rsp),
        .rd_data (rd_data)
    );

    assign opcode = cmd_new[7:0];

    always_comb begin
        st_d     = st_q;
        go_alloc = 1'b0;
        go_free  = 1'b0;
        if (cmd_wr) st_d.cmd = cmd_new;

        if (pool_done) begin
            st_d.rsp.busy   = 1'b0;
            st_d.rsp.status = pool_ok ? ST_OK : ST_FAIL;
            st_d.rsp.result = pool_ok ? pool_id : '0;
        end

        if (cmd_wr && !st_q.rsp.busy) begin
            if (opcode == OP_ALLOC || opcode == OP_FREE) begin
                if (CAP_EN != 0) begin
                    st_d.rsp      = '0;
                    st_d.rsp.busy = 1'b1;
                    go_alloc      = (opcode == OP_ALLOC);
                    go_free       = (opcode == OP_FREE);
                end
            end else begin
                st_d.rsp        = '0;
                st_d.rsp.status = ST_UNDEF;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    a_r2_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.rsp.busy && !pool_done) |=> st_q.rsp.busy);

    a_r2_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        pool_done |=> !st_q.rsp.busy);

    a_r4_fail_code: assert property (@(posedge clk) disable iff (!rst_n)
        (pool_done && !pool_ok) |=> (st_q.rsp.status == ST_FAIL && st_q.rsp.result == '0));

    a_r7_busy_origin: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.rsp.busy) |-> $past(go_alloc || go_free));

    generate
        if (CAP_EN == 0) begin : g_nocap
            a_r10_never_busy: assert property (@(posedge clk) disable iff (!rst_n)
                !st_q.rsp.busy);
        end
    endgenerate
endmodule

// File: tb/vcmd_unit_bench.sv
module vcmd_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] wr_addr = '0;
    logic        wr_wide = 1'b0;
    logic [63:0] wr_data = '0;
    logic [11:0] rd_addr = '0;
    logic [63:0] rd_data, rd_data_nc;

    int checks = 0;
    int errors = 0;
    logic [15:0] used = '0;

    always #10 clk = ~clk;

    vcmd_unit u_vcmd_unit (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_wide(wr_wide), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data));

    vcmd_unit #(.CAP_EN(0)) u_vcmd_unit_nocap (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_wide(wr_wide), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data_nc));

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [11:0] a, output logic [63:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    // caller sits just after a falling edge
    task automatic wr(input logic [11:0] a, input logic wide, input logic [63:0] d);
        wr_en = 1'b1; wr_addr = a; wr_wide = wide; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_idle(input string req);
        logic [63:0] d;
        for (int n = 0; n < 50; n++) begin
            rd(12'hE20, d);
            if (!d[0]) return;
            @(negedge clk);
        end
        check(req, 64'h1, 64'h0);
    endtask

    function automatic logic [63:0] id_word(input int id);
        return 64'(id) << 8;
    endfunction

    task automatic do_alloc(input string req);
        logic [63:0] d, exp;
        int pick = -1;
        wr(12'hE10, 1'b1, 64'h1);
        rd(12'hE20, d);
        check("R2 busy after allocate", 64'(d[0]), 64'h1);
        wait_idle("R2 allocate completes");
        for (int i = 15; i >= 0; i--) if (!used[i]) pick = i;
        if (pick >= 0) begin
            used[pick] = 1'b1;
            exp = id_word(200 + pick);
        end else exp = 64'h4;
        rd(12'hE20, d);
        check(req, d, exp);
    endtask

    task automatic do_free(input int id, input string req);
        logic [63:0] d, exp;
        wr(12'hE10, 1'b1, (64'(id) << 8) | 64'h2);
        rd(12'hE20, d);
        check("R2 busy after free", 64'(d[0]), 64'h1);
        wait_idle("R2 free completes");
        if (id >= 200 && id < 216 && used[id-200]) begin
            used[id-200] = 1'b0;
            exp = 64'h0;
        end else exp = 64'h4;
        rd(12'hE20, d);
        check(req, d, exp);
    endtask

    task automatic t_reset;
        logic [63:0] d;
        rd(12'hE00, d); check("R1 capability word", d, 64'h1);
        check("R1 capability clear variant", rd_data_nc, 64'h0);
        rd(12'hE04, d); check("R1 capability upper", d, 64'h0);
        rd(12'hE20, d); check("R1 response reset", d, 64'h0);
        rd(12'hE24, d); check("R1 response upper", d, 64'h0);
    endtask

    task automatic t_alloc_basic;
        for (int k = 0; k < 3; k++) do_alloc("R3 lowest free identifier");
    endtask

    task automatic t_free_reuse;
        do_free(201, "R5 free allocated");
        do_alloc("R5 freed identifier reused");
    endtask

    task automatic t_bad_free;
        do_free(201, "R5 free again valid");
        do_free(201, "R6 free not allocated");
        do_free(100, "R6 free below range");
        do_free(216, "R6 free above range");
        do_free(20'hFFFFF, "R6 free at top");
    endtask

    task automatic t_undef;
        logic [63:0] d;
        logic [7:0] ops [3] = '{8'h00, 8'h03, 8'hFF};
        foreach (ops[k]) begin
            wr(12'hE10, 1'b1, 64'h00C8_0000_0000 | 64'(ops[k]));
            rd(12'hE20, d);
            check("R7 undefined opcode status", d, 64'h2);
        end
    endtask

    task automatic t_nocap;
        logic [63:0] d;
        wr(12'hE10, 1'b1, 64'h0);
        rd(12'hE20, d);
        check("R10 null posts on no-cap", rd_data_nc, 64'h2);
        do_alloc("R10 main allocates");
        check("R10 no-cap allocate ignored", rd_data_nc, 64'h2);
        do_free(201, "R10 main free");
        check("R10 no-cap free ignored", rd_data_nc, 64'h2);
        do_alloc("R10 main reallocate");
    endtask

    task automatic t_exhaust;
        int k = 0;
        while (used != 16'hFFFF && k < 20) begin
            do_alloc("R3 fill pool");
            k++;
        end
        do_alloc("R4 pool exhausted");
        do_free(210, "R8 status cleared after failure");
        do_alloc("R8 result after failure");
    endtask

    task automatic t_collide;
        logic [63:0] d;
        do_free(203, "R9 prepare free 203");
        do_free(204, "R9 prepare free 204");
        wr(12'hE10, 1'b1, 64'h1);
        wr(12'hE10, 1'b1, 64'h1);   // sampled as the first allocate posts
        used[3] = 1'b1;
        rd(12'hE20, d);
        check("R9 collision outcome", d, id_word(203));
        do_alloc("R9 second write dropped");
    endtask

    task automatic t_halves;
        logic [63:0] d;
        do_free(200, "R11 prepare free 200");
        do_free(201, "R11 prepare free 201");
        wr(12'hE10, 1'b0, 64'hFFFF_FFFF_0000_0001);
        wait_idle("R11 low write completes");
        used[0] = 1'b1;
        rd(12'hE20, d); check("R11 32-bit low write runs", d, id_word(200));
        wr(12'hE14, 1'b0, 64'h0000_0000_0000_ABCD);
        wait_idle("R11 high write completes");
        used[1] = 1'b1;
        rd(12'hE20, d); check("R11 high write reruns", d, id_word(201));
        rd(12'hE14, d); check("R11 command upper", d, 64'hABCD);
        rd(12'hE10, d); check("R11 command merged", d, 64'h0000_ABCD_0000_0001);
        wr(12'hE20, 1'b1, '1);
        rd(12'hE20, d); check("R11 response write ignored", d, id_word(201));
        wr(12'hE00, 1'b1, 64'h0);
        rd(12'hE00, d); check("R11 capability write ignored", d, 64'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_alloc_basic();
        t_free_reuse();
        t_bad_free();
        t_undef();
        t_nocap();
        t_exhaust();
        t_collide();
        t_halves();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule